// File: doc/BRIEF.md
# SMBus Target Command Decoder

This block is an SMBus target. An external management controller uses it to write commands and message bytes into the system and to read a few status bytes back. The block watches the SCL and SDA lines and finds start, repeated-start and stop conditions. It matches a 7-bit target address that software can reprogram, and it acknowledges the bytes it accepts. For a Byte Write it captures the command-code byte and the data byte. For a Byte Read it returns one status byte. The status bytes are built from live input signals and latched when the repeated-start address is accepted.

A write to register 0 is a system command. Each command becomes a one-cycle pulse toward the power-management logic, or it changes a status flag. Some outcomes depend on the current sleep state. Registers 4 and 5 hold two message bytes. A new write overwrites a message byte, and no lock protects it against a read that happens at the same time.

The block does not stretch SCL. Its only flow control is the ACK or NACK it gives on the bus. All other pins are plain levels or single-cycle pulses in the `clk` domain. The system clock must run well above SCL, because both lines are oversampled through a two-flop synchronizer.

Top module: `smbt_decoder`

## Requirements
- R1: After reset the target address is 7'h2C. Writing `tgt_addr_i` with `tgt_addr_we_i` high replaces it. A transaction whose address differs from the current one gets a NACK on its first byte and changes no state.
- R2: The direction bit (bit 0) of the first address byte and of the repeated-start address byte is ignored. A matching address is ACKed whatever that bit holds, and the write or read proceeds.
- R3: A Byte Write to register 4 or 5 stores the data byte in `msg0_o` or `msg1_o`. A later write overwrites it, and the other byte is unchanged.
- R4: Writing 1 to register 0 pulses `wake_o` for one cycle when `pwr_state_i` is nonzero (asleep). It pulses `smi_o` instead when `pwr_state_i` is 000 (S0).
- R5: Writing 2, 3, 4 or 6 to register 0 pulses, for one cycle, `pwrdn_o`, `rst_warm_o`, `rst_cold_o` or `wdt_reload_o` respectively. Command values 0, 7 and 9 to FFh produce no pulse and change no state. At most one action pulse is high in any cycle.
- R6: Writing 5 to register 0 drops `msg_en_o`. It stays low until the next reset. Reset leaves it high.
- R7: Writing 8 to register 0 sets `tsmi_sts_o` only when `pwr_state_i` is 000. In any other state the write is still ACKed but no flag is set. `tsmi_clr_i` clears the flag.
- R8: Read register 1 returns `pwr_state_i` in bits 2:0 with zeros above (000 = S0, 100 = S4, 101 = S5). Read register 0 and every register other than 1, 3 and 4 return 00h.
- R9: Read register 3 returns the 10-bit `wdt_count_i` in bits 5:0, clamped to 3Fh when the count is above 3Fh. Bits 7:6 read 0.
- R10: Read register 4 bits are: bit 0 = `intruder_i`, bit 3 = `wdt_2nd_to_i`, bit 7 = `alert_pin_i`, or 1 whenever `alert_dis_i` is high. All other bits read 0.
- R11: A Byte Write to a register other than 0, 4 or 5 is ACKed on all three bytes and discarded. No pulse, flag or message byte changes.
- R12: `sda_oe_o` is asserted only while SCL is low-phase driven for an ACK slot or a 0 data bit of a read byte. It is released after a stop and out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (also re-enables messaging) |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| tgt_addr_we_i | input | 1 | Load a new target address |
| tgt_addr_i | input | 7 | New target address |
| pwr_state_i | input | 3 | System power state code |
| wdt_count_i | input | 10 | Current watchdog count |
| intruder_i | input | 1 | Cover-open indication |
| wdt_2nd_to_i | input | 1 | Second watchdog timeout has occurred |
| alert_pin_i | input | 1 | Alert pin level |
| alert_dis_i | input | 1 | Alert function disabled |
| tsmi_clr_i | input | 1 | Clear the target-SMI flag |
| wake_o | output | 1 | Wake request pulse |
| smi_o | output | 1 | SMI request pulse |
| pwrdn_o | output | 1 | Unconditional power-down pulse |
| rst_warm_o | output | 1 | Reset without power cycling pulse |
| rst_cold_o | output | 1 | Reset with power cycling pulse |
| wdt_reload_o | output | 1 | Watchdog reload pulse |
| msg_en_o | output | 1 | Heartbeat/event messaging enabled |
| tsmi_sts_o | output | 1 | Target-SMI status flag |
| msg0_o | output | 8 | Message byte 0 |
| msg1_o | output | 8 | Message byte 1 |

## Verification
The bench sweeps the command values across the S0, S4 and S5 codes. A decoder that ignored the sleep state would wake an awake system, or it would set the target-SMI flag while asleep. The watchdog read is swept across the 3Fh boundary and up to the full 10-bit range. A design that truncated instead of clamping would return 00h for 40h and similar wrong values. The direction bits are flipped in both address phases, so a decoder that honoured them would NACK. Reserved write registers and a wrong address are exercised, so any stray pulse or overwritten message byte shows up at the ports.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WDAT,
    S_ADDR2,
    S_RDAT,
    S_WAIT
  } link_state_t;

  // write register selectors
  localparam logic [7:0] REG_CMD  = 8'h00;
  localparam logic [7:0] REG_MSG0 = 8'h04;
  localparam logic [7:0] REG_MSG1 = 8'h05;

  // command register codes
  localparam logic [7:0] CMD_WAKE   = 8'h01;
  localparam logic [7:0] CMD_PWRDN  = 8'h02;
  localparam logic [7:0] CMD_WARM   = 8'h03;
  localparam logic [7:0] CMD_COLD   = 8'h04;
  localparam logic [7:0] CMD_MSGOFF = 8'h05;
  localparam logic [7:0] CMD_RELOAD = 8'h06;
  localparam logic [7:0] CMD_TSMI   = 8'h08;

  // read register selectors
  localparam logic [7:0] RD_PWR  = 8'h01;
  localparam logic [7:0] RD_WDT  = 8'h03;
  localparam logic [7:0] RD_STAT = 8'h04;

  localparam logic [2:0] PS_S0 = 3'b000;

  // action pulse indices
  localparam int ACT_WAKE   = 0;
  localparam int ACT_SMI    = 1;
  localparam int ACT_PWRDN  = 2;
  localparam int ACT_WARM   = 3;
  localparam int ACT_COLD   = 4;
  localparam int ACT_RELOAD = 5;
  localparam int ACT_N      = 6;

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/smbt_link.sv
module smbt_link
  import smbt_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [DW-1:0] reg_sel,
  output logic [DW-1:0] wr_data
);

  localparam int            CW   = $clog2(DW + 1);
  localparam logic [CW-1:0] SLOT = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  link_state_t   st;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] rsh;
  logic [DW-1:0] full;
  logic          ack_q;
  logic          addr_hit;
  logic          receiving;

  assign full      = {shreg[DW-2:0], sda_s};
  // direction bit (full[0]) deliberately not compared
  assign addr_hit  = (full[DW-1:DW-AW] == tgt_addr);
  assign receiving = (st == S_ADDR) || (st == S_CMD) ||
                     (st == S_WDAT) || (st == S_ADDR2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      rsh     <= '0;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      reg_sel <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        st     <= S_IDLE;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= (st == S_WDAT) ? S_ADDR2 : S_ADDR;
        bcnt   <= '0;
        ack_q  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (receiving) begin
          if (bcnt != SLOT) begin
            shreg <= full;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == LAST) begin
              case (st)
                S_ADDR: ack_q <= addr_hit;
                S_CMD: begin
                  ack_q   <= 1'b1;
                  reg_sel <= full;
                end
                S_WDAT: begin
                  ack_q   <= 1'b1;
                  wr_stb  <= 1'b1;
                  wr_data <= full;
                end
                default: begin
                  ack_q <= addr_hit;
                  rsh   <= rd_data;
                end
              endcase
            end
          end else begin
            bcnt <= '0;
            case (st)
              S_ADDR:  st <= ack_q ? S_CMD : S_IDLE;
              S_CMD:   st <= S_WDAT;
              S_WDAT:  st <= S_WAIT;
              default: st <= ack_q ? S_RDAT : S_IDLE;
            endcase
          end
        end else if (st == S_RDAT) begin
          if (bcnt != SLOT) begin
            rsh  <= {rsh[DW-2:0], 1'b0};
            bcnt <= bcnt + 1'b1;
          end else begin
            bcnt <= '0;
            st   <= S_WAIT;
          end
        end
      end else if (scl_fall) begin
        if (receiving)          sda_oe <= (bcnt == SLOT) && ack_q;
        else if (st == S_RDAT)  sda_oe <= (bcnt != SLOT) && !rsh[DW-1];
        else                    sda_oe <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile
  import smbt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int WDT_W   = 10,
  parameter int WDT_FLD = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [DW-1:0]    reg_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [2:0]       pwr_state,
  input  logic [WDT_W-1:0] wdt_count,
  input  logic             intruder,
  input  logic             wdt_2nd_to,
  input  logic             alert_pin,
  input  logic             alert_dis,
  input  logic             tsmi_clr,
  output logic [ACT_N-1:0] act,
  output logic             msg_en,
  output logic             tsmi_sts,
  output logic [DW-1:0]    msg0,
  output logic [DW-1:0]    msg1,
  output logic [DW-1:0]    rd_data
);

  localparam logic [WDT_W-1:0]   WDT_CAP = WDT_W'((1 << WDT_FLD) - 1);

  logic [ACT_N-1:0]   act_d;
  logic               asleep;
  logic               tsmi_set;
  logic               msg_kill;
  logic               cmd_wr;
  logic [WDT_FLD-1:0] wdt_sat;

  assign asleep = (pwr_state != PS_S0);
  assign cmd_wr = wr_stb && (reg_sel == REG_CMD);

  always_comb begin
    act_d    = '0;
    tsmi_set = 1'b0;
    msg_kill = 1'b0;
    if (cmd_wr) begin
      case (wr_data)
        CMD_WAKE: begin
          if (asleep) act_d[ACT_WAKE] = 1'b1;
          else        act_d[ACT_SMI]  = 1'b1;
        end
        CMD_PWRDN:  act_d[ACT_PWRDN]  = 1'b1;
        CMD_WARM:   act_d[ACT_WARM]   = 1'b1;
        CMD_COLD:   act_d[ACT_COLD]   = 1'b1;
        CMD_MSGOFF: msg_kill          = 1'b1;
        CMD_RELOAD: act_d[ACT_RELOAD] = 1'b1;
        CMD_TSMI:   tsmi_set          = !asleep;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= '0;
      msg_en   <= 1'b1;
      tsmi_sts <= 1'b0;
      msg0     <= '0;
      msg1     <= '0;
    end else begin
      act      <= act_d;
      msg_en   <= msg_en & ~msg_kill;
      tsmi_sts <= tsmi_set | (tsmi_sts & ~tsmi_clr);
      if (wr_stb && reg_sel == REG_MSG0) msg0 <= wr_data;
      if (wr_stb && reg_sel == REG_MSG1) msg1 <= wr_data;
    end
  end

  assign wdt_sat = (wdt_count > WDT_CAP) ? '1 : wdt_count[WDT_FLD-1:0];

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      RD_PWR:  rd_data[2:0]         = pwr_state;
      RD_WDT:  rd_data[WDT_FLD-1:0] = wdt_sat;
      RD_STAT: begin
        rd_data[0]    = intruder;
        rd_data[3]    = wdt_2nd_to;
        rd_data[DW-1] = alert_dis | alert_pin;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/smbt_decoder.sv
module smbt_decoder
  import smbt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR_RST = 7'h2C,
  parameter int         SYNC_STAGES  = 2,
  parameter int         WDT_W        = 10,
  parameter int         WDT_FLD      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             tgt_addr_we_i,
  input  logic [6:0]       tgt_addr_i,
  input  logic [2:0]       pwr_state_i,
  input  logic [WDT_W-1:0] wdt_count_i,
  input  logic             intruder_i,
  input  logic             wdt_2nd_to_i,
  input  logic             alert_pin_i,
  input  logic             alert_dis_i,
  input  logic             tsmi_clr_i,
  output logic             wake_o,
  output logic             smi_o,
  output logic             pwrdn_o,
  output logic             rst_warm_o,
  output logic             rst_cold_o,
  output logic             wdt_reload_o,
  output logic             msg_en_o,
  output logic             tsmi_sts_o,
  output logic [7:0]       msg0_o,
  output logic [7:0]       msg1_o
);

  localparam int AW = 7;
  localparam int DW = AW + 1;

  logic [AW-1:0]    tgt_addr_q;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_stb;
  logic [DW-1:0]    reg_sel, wr_data, rd_data;
  logic [ACT_N-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tgt_addr_q <= TGT_ADDR_RST;
    else if (tgt_addr_we_i) tgt_addr_q <= tgt_addr_i;
  end

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbt_link #(.AW(AW), .DW(DW)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .tgt_addr  (tgt_addr_q),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe_o),
    .wr_stb    (wr_stb),
    .reg_sel   (reg_sel),
    .wr_data   (wr_data)
  );

  smbt_regfile #(.DW(DW), .WDT_W(WDT_W), .WDT_FLD(WDT_FLD)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .pwr_state  (pwr_state_i),
    .wdt_count  (wdt_count_i),
    .intruder   (intruder_i),
    .wdt_2nd_to (wdt_2nd_to_i),
    .alert_pin  (alert_pin_i),
    .alert_dis  (alert_dis_i),
    .tsmi_clr   (tsmi_clr_i),
    .act        (act),
    .msg_en     (msg_en_o),
    .tsmi_sts   (tsmi_sts_o),
    .msg0       (msg0_o),
    .msg1       (msg1_o),
    .rd_data    (rd_data)
  );

  assign wake_o       = act[ACT_WAKE];
  assign smi_o        = act[ACT_SMI];
  assign pwrdn_o      = act[ACT_PWRDN];
  assign rst_warm_o   = act[ACT_WARM];
  assign rst_cold_o   = act[ACT_COLD];
  assign wdt_reload_o = act[ACT_RELOAD];

endmodule

// File: rtl/smbt_decoder_chk.sv
module smbt_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic [2:0] pwr_state_i,
  input logic       wake_o,
  input logic       smi_o,
  input logic       pwrdn_o,
  input logic       rst_warm_o,
  input logic       rst_cold_o,
  input logic       wdt_reload_o,
  input logic       msg_en_o,
  input logic       tsmi_sts_o
);

  // R5: never two actions in one cycle
  p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, smi_o, pwrdn_o, rst_warm_o, rst_cold_o, wdt_reload_o}));

  // R4: wake only from a sleeping state
  p_wake_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(pwr_state_i) != 3'b000));

  // R4: SMI only when awake
  p_smi_awake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> ($past(pwr_state_i) == 3'b000));

  // R6: messaging stays off once disabled
  p_msg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_en_o |=> !msg_en_o);

  // R7: flag is raised only from S0
  p_tsmi_s0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tsmi_sts_o) |-> ($past(pwr_state_i) == 3'b000));

  // R12: the line is grabbed only during SCL low
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

endmodule

bind smbt_decoder smbt_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_i        (scl_i),
  .sda_oe_o     (sda_oe_o),
  .pwr_state_i  (pwr_state_i),
  .wake_o       (wake_o),
  .smi_o        (smi_o),
  .pwrdn_o      (pwrdn_o),
  .rst_warm_o   (rst_warm_o),
  .rst_cold_o   (rst_cold_o),
  .wdt_reload_o (wdt_reload_o),
  .msg_en_o     (msg_en_o),
  .tsmi_sts_o   (tsmi_sts_o)
);

// File: tb/tb_smbt_decoder.sv
`timescale 1ns/1ps
module tb_smbt_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic       addr_we = 1'b0;
  logic [6:0] addr_val = 7'h00;
  logic [2:0] pwr = 3'b000;
  logic [9:0] wdt = 10'd0;
  logic       intr = 1'b0, sto = 1'b0, apin = 1'b0, adis = 1'b0, tclr = 1'b0;
  logic       wake, smi, pwrdn, rwarm, rcold, reload, msg_en, tsts;
  logic [7:0] msg0, msg1;

  int nvec = 0;
  int nfail = 0;
  int cnt [6];
  logic [6:0] cur_addr = 7'h2C;

  assign sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  smbt_decoder dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .tgt_addr_we_i(addr_we), .tgt_addr_i(addr_val), .pwr_state_i(pwr),
    .wdt_count_i(wdt), .intruder_i(intr), .wdt_2nd_to_i(sto),
    .alert_pin_i(apin), .alert_dis_i(adis), .tsmi_clr_i(tclr),
    .wake_o(wake), .smi_o(smi), .pwrdn_o(pwrdn), .rst_warm_o(rwarm),
    .rst_cold_o(rcold), .wdt_reload_o(reload), .msg_en_o(msg_en),
    .tsmi_sts_o(tsts), .msg0_o(msg0), .msg1_o(msg1)
  );

  always @(posedge clk) begin
    if (wake)   cnt[0] <= cnt[0] + 1;
    if (smi)    cnt[1] <= cnt[1] + 1;
    if (pwrdn)  cnt[2] <= cnt[2] + 1;
    if (rwarm)  cnt[3] <= cnt[3] + 1;
    if (rcold)  cnt[4] <= cnt[4] + 1;
    if (reload) cnt[5] <= cnt[5] + 1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_bit(logic b);
    sda_m = b; tick(5); scl = 1'b1; tick(10); scl = 1'b0; tick(5);
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1'b1; tick(5); scl = 1'b1; tick(5); b = sda_bus; tick(5); scl = 1'b0; tick(5);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(5); scl = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl = 1'b0; tick(5);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(5); scl = 1'b1; tick(5); sda_m = 1'b1; tick(10);
  endtask

  task automatic tx_byte(logic [7:0] v, output logic nak);
    for (int i = 7; i >= 0; i--) tx_bit(v[i]);
    rx_bit(nak);
  endtask

  task automatic rx_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rx_bit(v[i]);
    tx_bit(1'b1);
  endtask

  // acks: 1 = NACK seen on that byte
  task automatic wr_txn(logic [6:0] a, logic dir, logic [7:0] r, logic [7:0] d,
                        output logic [2:0] acks);
    acks = 3'b111;
    do_start();
    tx_byte({a, dir}, acks[2]);
    if (!acks[2]) begin
      tx_byte(r, acks[1]);
      tx_byte(d, acks[0]);
    end
    do_stop();
  endtask

  task automatic rd_txn(logic [6:0] a, logic d1, logic d2, logic [7:0] r,
                        output logic [7:0] v, output logic [2:0] acks);
    acks = 3'b111;
    v = 8'hEE;
    do_start();
    tx_byte({a, d1}, acks[2]);
    if (!acks[2]) begin
      tx_byte(r, acks[1]);
      do_start();
      tx_byte({a, d2}, acks[0]);
      if (!acks[0]) rx_byte(v);
    end
    do_stop();
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] r);
    case (r)
      8'h01: return {5'b0, pwr};
      8'h03: return (wdt > 10'd63) ? 8'd63 : {2'b0, wdt[5:0]};
      8'h04: return {adis | apin, 3'b000, sto, 2'b00, intr};
      default: return 8'h00;
    endcase
  endfunction

  task automatic apply_reset();
    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    cur_addr = 7'h2C;
  endtask

  task automatic run_all();
    logic [2:0] acks;
    logic [7:0] v;
    int base [6];
    logic [2:0] plist [3] = '{3'b000, 3'b100, 3'b101};
    logic [7:0] clist [11] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h06,
                               8'h07, 8'h08, 8'h09, 8'h80, 8'hFF};
    logic [7:0] rsv [7] = '{8'h01, 8'h02, 8'h03, 8'h06, 8'h07, 8'h10, 8'hFF};
    logic [9:0] wlist [10] = '{10'd0, 10'd1, 10'd31, 10'd62, 10'd63, 10'd64,
                               10'd65, 10'd127, 10'd511, 10'd1023};

    for (int i = 0; i < 6; i++) cnt[i] = 0;
    apply_reset();
    // reset state
    chk("R12 oe after reset", sda_oe, 0);
    chk("R6 msg_en after reset", msg_en, 1);
    chk("R7 flag after reset", tsts, 0);
    chk("R3 msg0 after reset", msg0, 0);

    // R1 / R3 default address, store and overwrite
    wr_txn(7'h2C, 1'b0, 8'h04, 8'hA5, acks);
    chk("R1 default addr acks", acks, 3'b000);
    chk("R3 msg0 write", msg0, 8'hA5);
    wr_txn(7'h2C, 1'b0, 8'h04, 8'h3C, acks);
    chk("R3 msg0 overwrite", msg0, 8'h3C);
    wr_txn(7'h2C, 1'b0, 8'h05, 8'hC3, acks);
    chk("R3 msg1 write", msg1, 8'hC3);
    chk("R3 msg0 untouched", msg0, 8'h3C);
    // R2 direction bit set on a write
    wr_txn(7'h2C, 1'b1, 8'h05, 8'h5A, acks);
    chk("R2 dir=1 write acks", acks, 3'b000);
    chk("R2 dir=1 write data", msg1, 8'h5A);
    chk("R12 oe released after stop", sda_oe, 0);

    // R1 mismatch and reprogramming
    wr_txn(7'h2D, 1'b0, 8'h04, 8'h11, acks);
    chk("R1 mismatch nack", acks[2], 1);
    chk("R1 mismatch no write", msg0, 8'h3C);
    addr_val = 7'h15; addr_we = 1'b1; tick(1); addr_we = 1'b0; tick(2);
    cur_addr = 7'h15;
    wr_txn(7'h2C, 1'b0, 8'h04, 8'h22, acks);
    chk("R1 old addr nack", acks[2], 1);
    wr_txn(7'h15, 1'b0, 8'h04, 8'h77, acks);
    chk("R1 new addr acks", acks, 3'b000);
    chk("R1 new addr write", msg0, 8'h77);

    // R11 reserved write registers
    foreach (rsv[k]) begin
      for (int i = 0; i < 6; i++) base[i] = cnt[i];
      wr_txn(cur_addr, 1'b0, rsv[k], 8'h01, acks);
      tick(2);
      chk("R11 reserved reg acks", acks, 3'b000);
      for (int i = 0; i < 6; i++) chk("R11 reserved reg no pulse", cnt[i] - base[i], 0);
      chk("R11 msg0 kept", msg0, 8'h77);
      chk("R11 msg1 kept", msg1, 8'h5A);
      chk("R11 flag kept", tsts, 0);
    end

    // R4 R5 R7 command sweep across power states
    foreach (plist[p]) begin
      pwr = plist[p];
      foreach (clist[c]) begin
        int e [6];
        for (int i = 0; i < 6; i++) begin base[i] = cnt[i]; e[i] = 0; end
        if (clist[c] == 8'h01) begin
          if (pwr != 3'b000) e[0] = 1; else e[1] = 1;
        end
        if (clist[c] == 8'h02) e[2] = 1;
        if (clist[c] == 8'h03) e[3] = 1;
        if (clist[c] == 8'h04) e[4] = 1;
        if (clist[c] == 8'h06) e[5] = 1;
        wr_txn(cur_addr, 1'b0, 8'h00, clist[c], acks);
        tick(2);
        chk("R7 command acks", acks, 3'b000);
        chk("R4 wake count", cnt[0] - base[0], e[0]);
        chk("R4 smi count", cnt[1] - base[1], e[1]);
        for (int i = 2; i < 6; i++) chk("R5 action count", cnt[i] - base[i], e[i]);
        chk("R5 msg_en kept", msg_en, 1);
        chk("R7 flag", tsts, (clist[c] == 8'h08 && pwr == 3'b000) ? 1 : 0);
        tclr = 1'b1; tick(1); tclr = 1'b0; tick(2);
        chk("R7 flag cleared", tsts, 0);
      end
    end

    // R8 register sweep with both direction bit variants (R2)
    pwr = 3'b101; wdt = 10'd700; intr = 1'b1; sto = 1'b0; apin = 1'b0; adis = 1'b0;
    for (int r = 0; r < 18; r++) begin
      rd_txn(cur_addr, r[0], r[1], 8'(r), v, acks);
      chk("R2 read acks", acks, 3'b000);
      chk("R8 read value", v, exp_rd(8'(r)));
    end
    rd_txn(cur_addr, 1'b0, 1'b1, 8'hFF, v, acks);
    chk("R8 reserved FFh", v, 8'h00);
    chk("R12 oe idle after read", sda_oe, 0);
    for (int s = 0; s < 8; s++) begin
      pwr = 3'(s);
      rd_txn(cur_addr, 1'b0, 1'b1, 8'h01, v, acks);
      chk("R8 power state", v, {5'b0, pwr});
    end
    // R9 watchdog clamp
    foreach (wlist[w]) begin
      wdt = wlist[w];
      rd_txn(cur_addr, 1'b0, 1'b1, 8'h03, v, acks);
      chk("R9 watchdog field", v, exp_rd(8'h03));
    end
    // R10 status bits
    for (int m = 0; m < 16; m++) begin
      intr = m[0]; sto = m[1]; apin = m[2]; adis = m[3];
      rd_txn(cur_addr, 1'b0, 1'b1, 8'h04, v, acks);
      chk("R10 status byte", v, exp_rd(8'h04));
    end

    // R6 messaging disable is sticky until reset
    pwr = 3'b000;
    wr_txn(cur_addr, 1'b0, 8'h00, 8'h05, acks);
    tick(2);
    chk("R6 msg disabled", msg_en, 0);
    wr_txn(cur_addr, 1'b0, 8'h00, 8'h06, acks);
    tick(2);
    chk("R6 still disabled", msg_en, 0);
    apply_reset();
    chk("R6 re-enabled by reset", msg_en, 1);
    wr_txn(7'h2C, 1'b0, 8'h05, 8'h99, acks);
    chk("R1 default addr after reset", msg1, 8'h99);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule